// File: doc/BRIEF.md
# Paged Instruction Decoder with Skip Control

This block sits at the front of a small 8-bit core. Each cycle it may receive one 16-bit instruction word. It splits the word by format into the control fields that the datapath needs: operation class, ALU opcode, destination select, file address, bit number, literal sub-opcode and literal. It also keeps the program counter and a 3-bit code page. Jump and call targets are formed by placing the page above the 13-bit offset carried in the word. A return loads the PC from a popped return address. The return forms that restore the page also reload the page from the top three bits of that address.

Several instructions request that the following instruction be skipped: bit tests, compares against W, and increment/decrement-and-test. The ALU supplies a zero flag and the tested file byte. A skip does not alter the PC arithmetic. The next instruction that arrives is instead squashed into a no-op: it is reported as class NOP, it moves the PC by one, and it cannot jump, change the page or request a skip of its own.

Top module: `instr_skip_decoder`

## Requirements
- R1: While reset is asserted, and immediately after it is released, `pc` is 0, `page` is 0 and `squash` is 0.
- R2: When bits 15:9 of the word are not all zero and bits 15:12 are 0x0 to 0x6, the word is register format. `op_class` is 1 (ALU_REG), `alu_op` equals bits 15:10, `dest_file` equals bit 9 (1 = file register, 0 = W) and `reg_addr` equals bits 8:0.
- R3: Bits 15:12 of 0x8, 0x9 and 0xA/0xB give `op_class` 3 (bit clear), 4 (bit set) and 5 (bit test), with `bit_num` equal to bits 11:9 and `reg_addr` equal to bits 8:0.
- R4: Bits 15:12 = 0x7 (except sub-opcode 0x8) gives `op_class` 2 (ALU_LIT), with `lit_op` equal to bits 11:8 and `literal` equal to bits 7:0.
- R5: Bits 15:13 = 0x7 is a jump (`op_class` 6) and 0x6 a call (`op_class` 7). `target` is {page, bits 12:0}, and `pc` takes that value on the next clock.
- R6: A word with bits 15:3 equal to 2 (0x0010 to 0x0017) is a page set (`op_class` 10). `page` takes bits 2:0 on the next clock.
- R7: Word 0x0007, and literal sub-opcode 0x8, are returns that restore the page (`op_class` 9). On the next clock `pc` becomes `ret_addr` and `page` becomes `ret_addr[15:13]`.
- R8: Word 0x0002 is a plain return (`op_class` 8). `pc` becomes `ret_addr` and `page` is unchanged.
- R9: Bit test with bits 15:12 = 0xB asserts `skip_next` when `file_byte[bit_num]` is 1. With 0xA it asserts `skip_next` when that bit is 0.
- R10: Register opcode 0x10 asserts `skip_next` on `alu_zero` when bit 9 is 1, and on not `alu_zero` when bit 9 is 0. Literal sub-opcode 0x7 skips on `alu_zero` and 0x6 skips on not `alu_zero`.
- R11: Register opcodes 0x0B and 0x0F skip when `alu_zero` is 1. Register opcodes 0x13 and 0x16 skip when `alu_zero` is 0.
- R12: After `skip_next`, `squash` is 1 and the next valid word is reported as `op_class` 0. That word advances `pc` by exactly one, leaves `page` unchanged and never asserts `skip_next`. `squash` then returns to 0.
- R13: In cycles with `insn_valid` low, `pc`, `page` and `squash` hold their values, so a pending squash waits for the next valid word.
- R14: Word 0x0000 gives `op_class` 0 and other words with bits 15:9 zero not covered above give `op_class` 11 (SYS). Every valid word other than jump, call or return advances `pc` by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| insn_valid | input | 1 | An instruction word is presented this cycle |
| insn | input | 16 | Instruction word |
| alu_zero | input | 1 | Zero result of the ALU for this instruction |
| file_byte | input | 8 | File register byte read for a bit test |
| ret_addr | input | 16 | Return address popped from the call stack |
| op_class | output | 4 | Operation class code |
| alu_op | output | 6 | Register-format opcode (bits 15:10) |
| dest_file | output | 1 | Destination select: 1 file register, 0 W |
| reg_addr | output | 9 | File register address |
| bit_num | output | 3 | Bit number for bit operations |
| lit_op | output | 4 | Literal-format sub-opcode |
| literal | output | 8 | 8-bit literal |
| target | output | 16 | Jump or call target {page, offset} |
| skip_next | output | 1 | The current word requests a skip of the next one |
| squash | output | 1 | The current (or next valid) word is squashed |
| pc | output | 16 | Program counter |
| page | output | 3 | Code page register |

## Verification
The assertions check the control-flow rules on every cycle. A squashed word is always a NOP and never asks for a skip. A skip always arms the squash, and the squash always clears once it is used. Page-set, jump and return load exactly the values the word or the return address carries. Plain returns and idle cycles leave the state untouched, and ordinary words step the PC by one. The field slicing of each format can only be shown by the bench's directed words. The bench also covers each skip condition in its taken and not-taken polarity, a skip word that is itself squashed, and a pending squash that survives idle cycles.

// File: rtl/idec_pkg.sv
package idec_pkg;

  typedef enum logic [3:0] {
    OPC_NOP      = 4'd0,
    OPC_ALU_REG  = 4'd1,
    OPC_ALU_LIT  = 4'd2,
    OPC_BIT_CLR  = 4'd3,
    OPC_BIT_SET  = 4'd4,
    OPC_BIT_TEST = 4'd5,
    OPC_JUMP     = 4'd6,
    OPC_CALL     = 4'd7,
    OPC_RET      = 4'd8,
    OPC_RET_PAGE = 4'd9,
    OPC_PAGE_SET = 4'd10,
    OPC_SYS      = 4'd11
  } op_class_e;

  typedef enum logic [2:0] {
    SKC_NONE  = 3'd0,
    SKC_ZERO  = 3'd1,
    SKC_NZERO = 3'd2,
    SKC_BSET  = 3'd3,
    SKC_BCLR  = 3'd4
  } skip_cond_e;

  // Skip decision from the condition kind and the datapath observations.
  function automatic logic skip_hit(input skip_cond_e kind, input logic zero,
                                    input logic [7:0] fbyte, input logic [2:0] bn);
    logic bitv;
    bitv = fbyte[bn];
    case (kind)
      SKC_ZERO:  skip_hit = zero;
      SKC_NZERO: skip_hit = !zero;
      SKC_BSET:  skip_hit = bitv;
      SKC_BCLR:  skip_hit = !bitv;
      default:   skip_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/idec_decode.sv
module idec_decode
  import idec_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int OFFS_W = 13
) (
  input  logic [15:0]              insn,
  input  logic                     kill,
  input  logic [PAGE_W-1:0]        page,
  output op_class_e                op_class,
  output skip_cond_e               skip_kind,
  output logic [5:0]               alu_op,
  output logic                     dest_file,
  output logic [8:0]               reg_addr,
  output logic [2:0]               bit_num,
  output logic [3:0]               lit_op,
  output logic [7:0]               literal,
  output logic [PAGE_W+OFFS_W-1:0] target,
  output logic [PAGE_W-1:0]        page_val
);
  logic [2:0] f_op3;
  logic [3:0] f_op4;
  logic [5:0] f_op6;
  logic       special_grp;

  assign f_op3       = insn[15:13];
  assign f_op4       = insn[15:12];
  assign f_op6       = insn[15:10];
  assign special_grp = (insn[15:9] == 7'd0);

  assign alu_op    = f_op6;
  assign dest_file = insn[9];
  assign reg_addr  = insn[8:0];
  assign bit_num   = insn[11:9];
  assign lit_op    = insn[11:8];
  assign literal   = insn[7:0];
  assign target    = {page, insn[OFFS_W-1:0]};
  assign page_val  = insn[PAGE_W-1:0];

  op_class_e  cls_raw;
  skip_cond_e sk_raw;

  always_comb begin
    cls_raw = OPC_ALU_REG;
    sk_raw  = SKC_NONE;
    if (f_op3 == 3'b110) begin
      cls_raw = OPC_CALL;
    end else if (f_op3 == 3'b111) begin
      cls_raw = OPC_JUMP;
    end else if (f_op4 == 4'h7) begin
      cls_raw = OPC_ALU_LIT;
      case (insn[11:8])
        4'h8: cls_raw = OPC_RET_PAGE;
        4'h7: sk_raw  = SKC_ZERO;
        4'h6: sk_raw  = SKC_NZERO;
        default: ;
      endcase
    end else if (f_op4[3:2] == 2'b10) begin
      case (f_op4[1:0])
        2'd0: cls_raw = OPC_BIT_CLR;
        2'd1: cls_raw = OPC_BIT_SET;
        2'd2: begin cls_raw = OPC_BIT_TEST; sk_raw = SKC_BCLR; end
        default: begin cls_raw = OPC_BIT_TEST; sk_raw = SKC_BSET; end
      endcase
    end else if (special_grp) begin
      if (insn[8:0] == 9'd0)       cls_raw = OPC_NOP;
      else if (insn[8:0] == 9'd2)  cls_raw = OPC_RET;
      else if (insn[8:0] == 9'd7)  cls_raw = OPC_RET_PAGE;
      else if (insn[8:3] == 6'd2)  cls_raw = OPC_PAGE_SET;
      else                         cls_raw = OPC_SYS;
    end else begin
      case (f_op6)
        6'h10:        sk_raw = insn[9] ? SKC_ZERO : SKC_NZERO;
        6'h0B, 6'h0F: sk_raw = SKC_ZERO;
        6'h13, 6'h16: sk_raw = SKC_NZERO;
        default: ;
      endcase
    end
  end

  assign op_class  = kill ? OPC_NOP  : cls_raw;
  assign skip_kind = kill ? SKC_NONE : sk_raw;
endmodule

// File: rtl/idec_skip.sv
module idec_skip
  import idec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  skip_cond_e skip_kind,
  input  logic       alu_zero,
  input  logic [7:0] file_byte,
  input  logic [2:0] bit_num,
  output logic       skip_next,
  output logic       squash
);
  logic pend_q;

  assign skip_next = valid && skip_hit(skip_kind, alu_zero, file_byte, bit_num);
  assign squash    = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (valid) pend_q <= skip_next;
  end
endmodule

// File: rtl/idec_pc.sv
module idec_pc
  import idec_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int OFFS_W = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid,
  input  op_class_e                op_class,
  input  logic [PAGE_W+OFFS_W-1:0] target,
  input  logic [PAGE_W+OFFS_W-1:0] ret_addr,
  input  logic [PAGE_W-1:0]        page_val,
  output logic [PAGE_W+OFFS_W-1:0] pc,
  output logic [PAGE_W-1:0]        page
);
  localparam int PC_W = PAGE_W + OFFS_W;

  logic [PC_W-1:0]   pc_q, pc_d;
  logic [PAGE_W-1:0] page_q, page_d;

  always_comb begin
    pc_d   = pc_q + PC_W'(1);
    page_d = page_q;
    case (op_class)
      OPC_JUMP, OPC_CALL: pc_d = target;
      OPC_RET:            pc_d = ret_addr;
      OPC_RET_PAGE: begin
        pc_d   = ret_addr;
        page_d = ret_addr[PC_W-1:OFFS_W];
      end
      OPC_PAGE_SET:       page_d = page_val;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      page_q <= '0;
    end else if (valid) begin
      pc_q   <= pc_d;
      page_q <= page_d;
    end
  end

  assign pc   = pc_q;
  assign page = page_q;
endmodule

// File: rtl/instr_skip_decoder.sv
module instr_skip_decoder
  import idec_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int OFFS_W = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     insn_valid,
  input  logic [15:0]              insn,
  input  logic                     alu_zero,
  input  logic [7:0]               file_byte,
  input  logic [PAGE_W+OFFS_W-1:0] ret_addr,
  output logic [3:0]               op_class,
  output logic [5:0]               alu_op,
  output logic                     dest_file,
  output logic [8:0]               reg_addr,
  output logic [2:0]               bit_num,
  output logic [3:0]               lit_op,
  output logic [7:0]               literal,
  output logic [PAGE_W+OFFS_W-1:0] target,
  output logic                     skip_next,
  output logic                     squash,
  output logic [PAGE_W+OFFS_W-1:0] pc,
  output logic [PAGE_W-1:0]        page
);
  op_class_e         cls;
  skip_cond_e        skind;
  logic [PAGE_W-1:0] page_val;

  idec_decode #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) u_dec (
    .insn      (insn),
    .kill      (squash),
    .page      (page),
    .op_class  (cls),
    .skip_kind (skind),
    .alu_op    (alu_op),
    .dest_file (dest_file),
    .reg_addr  (reg_addr),
    .bit_num   (bit_num),
    .lit_op    (lit_op),
    .literal   (literal),
    .target    (target),
    .page_val  (page_val)
  );

  idec_skip u_skip (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (insn_valid),
    .skip_kind (skind),
    .alu_zero  (alu_zero),
    .file_byte (file_byte),
    .bit_num   (bit_num),
    .skip_next (skip_next),
    .squash    (squash)
  );

  idec_pc #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (insn_valid),
    .op_class (cls),
    .target   (target),
    .ret_addr (ret_addr),
    .page_val (page_val),
    .pc       (pc),
    .page     (page)
  );

  assign op_class = cls;
endmodule

// File: rtl/idec_chk.sv
module idec_chk #(
  parameter int PAGE_W = 3,
  parameter int OFFS_W = 13
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     insn_valid,
  input logic [15:0]              insn,
  input logic [PAGE_W+OFFS_W-1:0] ret_addr,
  input logic [3:0]               op_class,
  input logic                     skip_next,
  input logic                     squash,
  input logic [PAGE_W+OFFS_W-1:0] pc,
  input logic [PAGE_W-1:0]        page
);
  localparam int PC_W = PAGE_W + OFFS_W;

  assert_squash_is_nop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> (op_class == 4'd0 && !skip_next));

  assert_skip_arms_squash_R12: assert property (@(posedge clk) disable iff (!rst_n)
    skip_next |=> squash);

  assert_squash_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && squash) |=> !squash);

  assert_page_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && op_class == 4'd10) |=> page == $past(insn[PAGE_W-1:0]));

  assert_jump_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && op_class == 4'd6) |=> pc == {$past(page), $past(insn[OFFS_W-1:0])});

  assert_ret_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && op_class == 4'd9) |=>
      (pc == $past(ret_addr) && page == $past(ret_addr[PC_W-1:OFFS_W])));

  assert_ret_keeps_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && op_class == 4'd8) |=> (page == $past(page) && pc == $past(ret_addr)));

  assert_idle_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> ($stable(pc) && $stable(page) && squash == $past(squash)));

  assert_step_by_one_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && op_class <= 4'd5) |=> pc == $past(pc) + PC_W'(1));
endmodule

bind instr_skip_decoder idec_chk #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_valid (insn_valid),
  .insn       (insn),
  .ret_addr   (ret_addr),
  .op_class   (op_class),
  .skip_next  (skip_next),
  .squash     (squash),
  .pc         (pc),
  .page       (page)
);

// File: tb/instr_skip_decoder_tb.sv
module instr_skip_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_valid;
  logic [15:0] insn;
  logic        alu_zero;
  logic [7:0]  file_byte;
  logic [15:0] ret_addr;
  logic [3:0]  op_class;
  logic [5:0]  alu_op;
  logic        dest_file;
  logic [8:0]  reg_addr;
  logic [2:0]  bit_num;
  logic [3:0]  lit_op;
  logic [7:0]  literal;
  logic [15:0] target;
  logic        skip_next;
  logic        squash;
  logic [15:0] pc;
  logic [2:0]  page;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [15:0] exp_pc;
  logic [2:0]  exp_page;

  logic [3:0]  g_cls;
  logic [5:0]  g_aop;
  logic        g_dest;
  logic [8:0]  g_addr;
  logic [2:0]  g_bit;
  logic [3:0]  g_lop;
  logic [7:0]  g_lit;
  logic [15:0] g_tgt;
  logic        g_skip;
  logic        g_sq;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_skip_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .alu_zero(alu_zero), .file_byte(file_byte), .ret_addr(ret_addr),
    .op_class(op_class), .alu_op(alu_op), .dest_file(dest_file),
    .reg_addr(reg_addr), .bit_num(bit_num), .lit_op(lit_op), .literal(literal),
    .target(target), .skip_next(skip_next), .squash(squash), .pc(pc), .page(page)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Present one word at a falling edge, capture decode, then pass the rising edge.
  task automatic do_insn(input logic [15:0] w, input logic z, input logic [7:0] fb,
                         input logic [15:0] ra);
    insn_valid = 1'b1; insn = w; alu_zero = z; file_byte = fb; ret_addr = ra;
    #1;
    g_cls = op_class; g_aop = alu_op; g_dest = dest_file; g_addr = reg_addr;
    g_bit = bit_num; g_lop = lit_op; g_lit = literal; g_tgt = target;
    g_skip = skip_next; g_sq = squash;
    @(negedge clk);
  endtask

  function automatic logic [15:0] reg_word(input logic [5:0] op, input logic d,
                                           input logic [8:0] a);
    return {op, d, a};
  endfunction

  // A skip candidate followed by a jump; the jump must be squashed if the skip was taken.
  task automatic skip_case(input string tag, input logic [15:0] w, input logic z,
                           input logic [7:0] fb, input logic exp_skip);
    do_insn(w, z, fb, 16'h0);
    check({tag, " skip_next"}, 32'(g_skip), 32'(exp_skip));
    exp_pc = exp_pc + 16'd1;
    check({tag, " pc after candidate"}, 32'(pc), 32'(exp_pc));
    do_insn(16'hE000, 1'b1, 8'hFF, 16'h0);
    if (exp_skip) begin
      check({tag, " follower squashed R12"}, 32'(g_sq), 32'd1);
      check({tag, " follower class NOP R12"}, 32'(g_cls), 32'd0);
      exp_pc = exp_pc + 16'd1;
    end else begin
      check({tag, " follower live"}, 32'(g_sq), 32'd0);
      check({tag, " follower class JUMP"}, 32'(g_cls), 32'd6);
      exp_pc = {exp_page, 13'h0};
    end
    check({tag, " pc after follower"}, 32'(pc), 32'(exp_pc));
  endtask

  task automatic t_reset;
    check("R1 pc", 32'(pc), 32'h0);
    check("R1 page", 32'(page), 32'h0);
    check("R1 squash", 32'(squash), 32'h0);
    exp_pc = 16'h0; exp_page = 3'd0;
  endtask

  task automatic t_reg_fields;
    do_insn(reg_word(6'h05, 1'b1, 9'h1A3), 1'b0, 8'h00, 16'h0);
    check("R2 class", 32'(g_cls), 32'd1);
    check("R2 alu_op", 32'(g_aop), 32'h05);
    check("R2 dest", 32'(g_dest), 32'd1);
    check("R2 addr", 32'(g_addr), 32'h1A3);
    check("R2 no skip", 32'(g_skip), 32'd0);
    exp_pc = exp_pc + 16'd1;
    check("R14 pc step", 32'(pc), 32'(exp_pc));
    do_insn(reg_word(6'h14, 1'b0, 9'h00F), 1'b1, 8'h00, 16'h0);
    check("R2 dest W", 32'(g_dest), 32'd0);
    check("R2 alu_op 14", 32'(g_aop), 32'h14);
    exp_pc = exp_pc + 16'd1;
  endtask

  task automatic t_bit_fields;
    do_insn({4'h9, 3'd5, 9'h0AB}, 1'b0, 8'h00, 16'h0);
    check("R3 set class", 32'(g_cls), 32'd4);
    check("R3 bit", 32'(g_bit), 32'd5);
    check("R3 addr", 32'(g_addr), 32'h0AB);
    do_insn({4'h8, 3'd0, 9'h1FF}, 1'b0, 8'h00, 16'h0);
    check("R3 clr class", 32'(g_cls), 32'd3);
    check("R3 bit0", 32'(g_bit), 32'd0);
    exp_pc = exp_pc + 16'd2;
    check("R3 pc", 32'(pc), 32'(exp_pc));
  endtask

  task automatic t_literal;
    do_insn({4'h7, 4'hE, 8'h5C}, 1'b0, 8'h00, 16'h0);
    check("R4 class", 32'(g_cls), 32'd2);
    check("R4 lit_op", 32'(g_lop), 32'hE);
    check("R4 literal", 32'(g_lit), 32'h5C);
    exp_pc = exp_pc + 16'd1;
  endtask

  task automatic t_page_jump;
    do_insn(16'h0015, 1'b0, 8'h00, 16'h0);
    check("R6 class", 32'(g_cls), 32'd10);
    exp_page = 3'd5; exp_pc = exp_pc + 16'd1;
    check("R6 page", 32'(page), 32'(exp_page));
    do_insn(16'hE123, 1'b0, 8'h00, 16'h0);
    check("R5 jump class", 32'(g_cls), 32'd6);
    check("R5 jump target", 32'(g_tgt), 32'hA123);
    exp_pc = 16'hA123;
    check("R5 jump pc", 32'(pc), 32'(exp_pc));
    do_insn(16'hDFFF, 1'b0, 8'h00, 16'h0);
    check("R5 call class", 32'(g_cls), 32'd7);
    exp_pc = 16'hBFFF;
    check("R5 call pc", 32'(pc), 32'(exp_pc));
  endtask

  task automatic t_returns;
    do_insn(16'h0002, 1'b0, 8'h00, 16'h4321);
    check("R8 class", 32'(g_cls), 32'd8);
    exp_pc = 16'h4321;
    check("R8 pc", 32'(pc), 32'(exp_pc));
    check("R8 page kept", 32'(page), 32'(exp_page));
    do_insn(16'h0007, 1'b0, 8'h00, 16'h6456);
    check("R7 class", 32'(g_cls), 32'd9);
    exp_pc = 16'h6456; exp_page = 3'd3;
    check("R7 pc", 32'(pc), 32'(exp_pc));
    check("R7 page", 32'(page), 32'(exp_page));
    do_insn({4'h7, 4'h8, 8'h11}, 1'b0, 8'h00, 16'hE000);
    check("R7 literal ret class", 32'(g_cls), 32'd9);
    check("R7 literal ret literal", 32'(g_lit), 32'h11);
    exp_pc = 16'hE000; exp_page = 3'd7;
    check("R7 literal ret page", 32'(page), 32'(exp_page));
    check("R7 literal ret pc", 32'(pc), 32'(exp_pc));
  endtask

  task automatic t_special;
    do_insn(16'h0000, 1'b0, 8'h00, 16'h0);
    check("R14 nop class", 32'(g_cls), 32'd0);
    do_insn(16'h0001, 1'b0, 8'h00, 16'h0);
    check("R14 sys class", 32'(g_cls), 32'd11);
    exp_pc = exp_pc + 16'd2;
    check("R14 pc", 32'(pc), 32'(exp_pc));
  endtask

  task automatic t_bit_skip;
    skip_case("R9 set-skip hit",   {4'hB, 3'd2, 9'h011}, 1'b0, 8'h04, 1'b1);
    skip_case("R9 set-skip miss",  {4'hB, 3'd2, 9'h011}, 1'b0, 8'hFB, 1'b0);
    skip_case("R9 clr-skip hit",   {4'hA, 3'd7, 9'h012}, 1'b0, 8'h7F, 1'b1);
    skip_case("R9 clr-skip miss",  {4'hA, 3'd7, 9'h012}, 1'b0, 8'h80, 1'b0);
  endtask

  task automatic t_cmp_skip;
    skip_case("R10 eq-form equal",   reg_word(6'h10, 1'b1, 9'h020), 1'b1, 8'h00, 1'b1);
    skip_case("R10 eq-form differ",  reg_word(6'h10, 1'b1, 9'h020), 1'b0, 8'h00, 1'b0);
    skip_case("R10 ne-form equal",   reg_word(6'h10, 1'b0, 9'h020), 1'b1, 8'h00, 1'b0);
    skip_case("R10 ne-form differ",  reg_word(6'h10, 1'b0, 9'h020), 1'b0, 8'h00, 1'b1);
    skip_case("R10 lit eq hit",      {4'h7, 4'h7, 8'h3C}, 1'b1, 8'h00, 1'b1);
    skip_case("R10 lit ne equal",    {4'h7, 4'h6, 8'h3C}, 1'b1, 8'h00, 1'b0);
    skip_case("R10 lit ne differ",   {4'h7, 4'h6, 8'h3C}, 1'b0, 8'h00, 1'b1);
  endtask

  task automatic t_incdec_skip;
    skip_case("R11 0B zero",    reg_word(6'h0B, 1'b1, 9'h030), 1'b1, 8'h00, 1'b1);
    skip_case("R11 0B nonzero", reg_word(6'h0B, 1'b1, 9'h030), 1'b0, 8'h00, 1'b0);
    skip_case("R11 0F zero",    reg_word(6'h0F, 1'b0, 9'h030), 1'b1, 8'h00, 1'b1);
    skip_case("R11 13 zero",    reg_word(6'h13, 1'b1, 9'h030), 1'b1, 8'h00, 1'b0);
    skip_case("R11 13 nonzero", reg_word(6'h13, 1'b1, 9'h030), 1'b0, 8'h00, 1'b1);
    skip_case("R11 16 nonzero", reg_word(6'h16, 1'b0, 9'h030), 1'b0, 8'h00, 1'b1);
  endtask

  task automatic t_squash_chain;
    do_insn({4'hB, 3'd0, 9'h001}, 1'b0, 8'h01, 16'h0);
    check("R12 first skip", 32'(g_skip), 32'd1);
    do_insn({4'hB, 3'd0, 9'h001}, 1'b0, 8'h01, 16'h0);
    check("R12 squashed skip word", 32'(g_sq), 32'd1);
    check("R12 squashed word no skip", 32'(g_skip), 32'd0);
    do_insn(16'h0015, 1'b0, 8'h00, 16'h0);
    check("R12 third word live", 32'(g_sq), 32'd0);
    exp_pc = exp_pc + 16'd3; exp_page = 3'd5;
    check("R12 chain pc", 32'(pc), 32'(exp_pc));
    check("R12 chain page", 32'(page), 32'(exp_page));
  endtask

  task automatic t_idle;
    do_insn(reg_word(6'h10, 1'b1, 9'h005), 1'b1, 8'h00, 16'h0);
    check("R13 skip set", 32'(g_skip), 32'd1);
    exp_pc = exp_pc + 16'd1;
    insn_valid = 1'b0; insn = 16'hE000;
    for (int i = 0; i < 3; i++) @(negedge clk);
    check("R13 pc held", 32'(pc), 32'(exp_pc));
    check("R13 squash held", 32'(squash), 32'd1);
    do_insn(16'h0012, 1'b0, 8'h00, 16'h0);
    check("R13 squashed page set class", 32'(g_cls), 32'd0);
    exp_pc = exp_pc + 16'd1;
    check("R12 page untouched", 32'(page), 32'(exp_page));
    check("R13 pc after squash", 32'(pc), 32'(exp_pc));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; insn_valid = 1'b0; insn = 16'h0; alu_zero = 1'b0;
    file_byte = 8'h0; ret_addr = 16'h0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 squash in reset", 32'(squash), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_reg_fields;
    t_bit_fields;
    t_literal;
    t_page_jump;
    t_returns;
    t_special;
    t_bit_skip;
    t_cmp_skip;
    t_incdec_skip;
    t_squash_chain;
    t_idle;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule